// File: doc/BRIEF.md
# CAN Event Flag and Error Capture Register

This block is the read-only 32-bit event register of a CAN controller. It watches the controller's status lines and turns chosen changes on them into sticky interrupt flags. Each flag has its own enable. It also records two 8-bit diagnostic codes: the code that describes a bus error and the bit position at which arbitration was lost. Every flag is merged into one interrupt request line.

Software reads the whole word. The surrounding bus logic pulses `reg_rd` for one cycle per read. That pulse clears the sticky flags. It also frees both capture bytes so that each can take a new code. The receive flag is not sticky: it follows the receive-buffer status live and a read does not change it. A capture byte loads on the first event after it was freed. It then ignores later events until the next read, so software always sees the first error in a burst.

Top module: `canev_flag_capture`

## Requirements
- R1: Bit 0 equals `rx_full AND irq_en[0]` in the same cycle. A read does not clear it.
- R2: Bit 1 sets in the cycle after `tx1_free` rises from 0 to 1 while `irq_en[1]` is 1. The previous-value register resets to 0.
- R3: Bit 2 sets in the cycle after any change, rising or falling, of `err_warn` or `bus_off`. `irq_en[2]` must be 1 in the cycle of the change. A change seen while the enable is 0 sets nothing.
- R4: Bit 3 sets in the cycle after `overrun` rises from 0 to 1 while `irq_en[3]` is 1.
- R5: Bit 4 sets in the cycle after any cycle in which `sleeping`, `bus_active` and `irq_en[4]` are all 1.
- R6: A cycle with `reg_rd` high clears bits 1 to 6 in the following cycle. Bits 7 to 15 always read 0.
- R7: On `berr_strobe`, bits 23:16 take `berr_code` if that byte is free, and the byte then becomes held. Bit 5 sets if `irq_en[5]` is 1.
- R8: On `arb_strobe`, bits 31:24 take `arb_code` if that byte is free, and the byte then becomes held. Bit 6 sets if `irq_en[6]` is 1.
- R9: A held capture byte ignores further strobes. It keeps its value, even across the read that frees it, until a strobe arrives after that read.
- R10: When a set event and a read happen in the same cycle, the set wins. The flag stays 1, and a strobe loads its code and holds the byte again.
- R11: `irq` is 1 exactly when any of bits 0 to 6 is 1. After reset all register bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_full | input | 1 | Receive buffer holds a message |
| tx1_free | input | 1 | Transmit buffer 1 available |
| err_warn | input | 1 | Error warning status |
| bus_off | input | 1 | Bus-off status |
| overrun | input | 1 | Data overrun status |
| sleeping | input | 1 | Controller is in sleep mode |
| bus_active | input | 1 | Activity detected on the bus |
| irq_en | input | 7 | Per-flag enables, bit n enables flag n |
| berr_strobe | input | 1 | Bus error occurred this cycle |
| berr_code | input | 8 | Bus error code |
| arb_strobe | input | 1 | Arbitration lost this cycle |
| arb_code | input | 8 | Arbitration-lost bit position code |
| reg_rd | input | 1 | One-cycle register read pulse |
| reg_data | output | 32 | Register value |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench first holds a capture byte with one code and then sends a second strobe. A design that overwrites held bytes would show the later code instead of the first. It drives a falling edge on the error status to show that clearing the status also raises bit 2, which a design that detects only rising edges misses. It issues a read while the receive flag is live and checks that the flag survives, which catches a design that clears every flag on a read. It pulses a read and a strobe in the same cycle; a design where the clear has priority would drop the event and leave the byte free.

// File: rtl/canev_pkg.sv
package canev_pkg;

    localparam int REG_W     = 32;
    localparam int CODE_W    = 8;
    localparam int FLAG_N    = 7;
    localparam int STICKY_LO = 1;
    localparam int STICKY_HI = FLAG_N - 1;
    localparam int PAD_W     = 16 - FLAG_N;
    localparam int EDGE_W    = 4;
    localparam int CAP_N     = 2;

    localparam int F_RX   = 0;
    localparam int F_TX1  = 1;
    localparam int F_ERR  = 2;
    localparam int F_OVR  = 3;
    localparam int F_WAKE = 4;
    localparam int F_BERR = 5;
    localparam int F_ARB  = 6;

    localparam int E_TX1  = 0;
    localparam int E_WARN = 1;
    localparam int E_BOFF = 2;
    localparam int E_OVR  = 3;

    localparam int C_BERR = 0;
    localparam int C_ARB  = 1;

    typedef logic [FLAG_N-1:0] flag_vec_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  strobe;
        code_t code;
    } cap_evt_t;

    typedef struct packed {
        code_t     arb;
        code_t     berr;
        flag_vec_t flags;
    } reg_view_t;

    function automatic logic [REG_W-1:0] pack_reg(input reg_view_t v);
        return {v.arb, v.berr, {PAD_W{1'b0}}, v.flags};
    endfunction

endpackage

// File: rtl/canev_edge_det.sv
module canev_edge_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    output logic [W-1:0] rise,
    output logic [W-1:0] change
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    assign rise   = cur & ~prev_q;
    assign change = cur ^ prev_q;
endmodule

// File: rtl/canev_flag_bank.sv
module canev_flag_bank #(
    parameter int LO = 1,
    parameter int HI = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd,
    input  logic [HI:LO] set_evt,
    output logic [HI:LO] flags
);
    logic [HI:LO] flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (rd ? '0 : flags_q) | set_evt;
    end

    assign flags = flags_q;
endmodule

// File: rtl/canev_code_hold.sv
module canev_code_hold
    import canev_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rd,
    input  cap_evt_t evt,
    output code_t    value,
    output logic     held
);
    code_t value_q;
    logic  held_q;
    logic  take;

    assign take = evt.strobe && (!held_q || rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            held_q  <= 1'b0;
        end else begin
            if (take) value_q <= evt.code;
            if (take)     held_q <= 1'b1;
            else if (rd)  held_q <= 1'b0;
        end
    end

    assign value = value_q;
    assign held  = held_q;
endmodule

// File: rtl/canev_flag_capture.sv
module canev_flag_capture
    import canev_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_full,
    input  logic        tx1_free,
    input  logic        err_warn,
    input  logic        bus_off,
    input  logic        overrun,
    input  logic        sleeping,
    input  logic        bus_active,
    input  logic [6:0]  irq_en,
    input  logic        berr_strobe,
    input  logic [7:0]  berr_code,
    input  logic        arb_strobe,
    input  logic [7:0]  arb_code,
    input  logic        reg_rd,
    output logic [31:0] reg_data,
    output logic        irq
);
    logic [EDGE_W-1:0]              stat_vec, stat_rise, stat_chg;
    logic [STICKY_HI:STICKY_LO]     set_evt, sticky;
    cap_evt_t                       cap_in   [CAP_N];
    code_t                          cap_val  [CAP_N];
    logic [CAP_N-1:0]               cap_held;
    reg_view_t                      view;
    logic                           berr_held, arb_held;

    assign stat_vec[E_TX1]  = tx1_free;
    assign stat_vec[E_WARN] = err_warn;
    assign stat_vec[E_BOFF] = bus_off;
    assign stat_vec[E_OVR]  = overrun;

    canev_edge_det #(.W(EDGE_W)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .cur    (stat_vec),
        .rise   (stat_rise),
        .change (stat_chg)
    );

    always_comb begin
        set_evt         = '0;
        set_evt[F_TX1]  = stat_rise[E_TX1] & irq_en[F_TX1];
        set_evt[F_ERR]  = (stat_chg[E_WARN] | stat_chg[E_BOFF]) & irq_en[F_ERR];
        set_evt[F_OVR]  = stat_rise[E_OVR] & irq_en[F_OVR];
        set_evt[F_WAKE] = sleeping & bus_active & irq_en[F_WAKE];
        set_evt[F_BERR] = berr_strobe & irq_en[F_BERR];
        set_evt[F_ARB]  = arb_strobe & irq_en[F_ARB];
    end

    canev_flag_bank #(.LO(STICKY_LO), .HI(STICKY_HI)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .rd      (reg_rd),
        .set_evt (set_evt),
        .flags   (sticky)
    );

    assign cap_in[C_BERR] = '{strobe: berr_strobe, code: berr_code};
    assign cap_in[C_ARB]  = '{strobe: arb_strobe,  code: arb_code};

    for (genvar g = 0; g < CAP_N; g++) begin : g_cap
        canev_code_hold u_hold (
            .clk   (clk),
            .rst   (rst),
            .rd    (reg_rd),
            .evt   (cap_in[g]),
            .value (cap_val[g]),
            .held  (cap_held[g])
        );
    end

    assign berr_held = cap_held[C_BERR];
    assign arb_held  = cap_held[C_ARB];

    always_comb begin
        view.flags       = '0;
        view.flags[F_RX] = rx_full & irq_en[F_RX];
        view.flags[STICKY_HI:STICKY_LO] = sticky;
        view.berr        = cap_val[C_BERR];
        view.arb         = cap_val[C_ARB];
    end

    assign reg_data = pack_reg(view);
    assign irq      = |view.flags;
endmodule

// File: rtl/canev_flag_capture_chk.sv
module canev_flag_capture_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx1_free,
    input logic        sleeping,
    input logic        bus_active,
    input logic [6:0]  irq_en,
    input logic        berr_strobe,
    input logic [7:0]  berr_code,
    input logic        arb_strobe,
    input logic        reg_rd,
    input logic [31:0] reg_data,
    input logic        irq,
    input logic        berr_held
);
    // R2
    tx1_rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (tx1_free && !$past(tx1_free) && irq_en[1]) |=> reg_data[1]);

    // R6
    read_clears_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !(sleeping && bus_active && irq_en[4])) |=> !reg_data[4]);

    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_data[15:7] == 9'd0);

    // R7
    berr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (berr_strobe && (!berr_held || reg_rd)) |=> reg_data[23:16] == $past(berr_code));

    // R9
    berr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (berr_held && !reg_rd) |=> $stable(reg_data[23:16]));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && arb_strobe && irq_en[6]) |=> reg_data[6]);

    // R11
    irq_merge_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (reg_data[6:0] != 7'd0));
endmodule

bind canev_flag_capture canev_flag_capture_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx1_free    (tx1_free),
    .sleeping    (sleeping),
    .bus_active  (bus_active),
    .irq_en      (irq_en),
    .berr_strobe (berr_strobe),
    .berr_code   (berr_code),
    .arb_strobe  (arb_strobe),
    .reg_rd      (reg_rd),
    .reg_data    (reg_data),
    .irq         (irq),
    .berr_held   (berr_held)
);

// File: tb/tb_canev_flag_capture.sv
module tb_canev_flag_capture;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_full, tx1_free, err_warn, bus_off, overrun, sleeping, bus_active;
    logic [6:0]  irq_en;
    logic        berr_strobe, arb_strobe, reg_rd;
    logic [7:0]  berr_code, arb_code;
    logic [31:0] reg_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    canev_flag_capture dut (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read();
        reg_rd = 1'b1; tick(); reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 reset data", reg_data, 32'h0);
        check("R11 reset irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_rx();
        rx_full = 1'b1; #1;
        check("R1 rx live", {31'd0, reg_data[0]}, 32'd1);
        check("R11 irq from rx", {31'd0, irq}, 32'd1);
        do_read();
        check("R1 rx survives read", {31'd0, reg_data[0]}, 32'd1);
        irq_en[0] = 1'b0; #1;
        check("R1 rx gated by enable", {31'd0, reg_data[0]}, 32'd0);
        irq_en[0] = 1'b1; rx_full = 1'b0; #1;
        check("R1 rx follows status", {31'd0, reg_data[0]}, 32'd0);
    endtask

    task automatic t_tx1();
        tx1_free = 1'b1; tick();
        check("R2 tx1 rise sets", {31'd0, reg_data[1]}, 32'd1);
        do_read();
        check("R6 read clears tx1", {31'd0, reg_data[1]}, 32'd0);
        tick();
        check("R2 level does not re-set", {31'd0, reg_data[1]}, 32'd0);
        tx1_free = 1'b0; tick();
        check("R2 fall does not set", {31'd0, reg_data[1]}, 32'd0);
    endtask

    task automatic t_err();
        err_warn = 1'b1; tick();
        check("R3 warn rise sets", {31'd0, reg_data[2]}, 32'd1);
        do_read();
        err_warn = 1'b0; tick();
        check("R3 warn fall sets", {31'd0, reg_data[2]}, 32'd1);
        do_read();
        bus_off = 1'b1; tick();
        check("R3 bus_off change sets", {31'd0, reg_data[2]}, 32'd1);
        do_read();
        irq_en[2] = 1'b0; bus_off = 1'b0; tick();
        irq_en[2] = 1'b1; tick();
        check("R3 change while disabled ignored", {31'd0, reg_data[2]}, 32'd0);
    endtask

    task automatic t_ovr();
        overrun = 1'b1; tick();
        check("R4 overrun rise sets", {31'd0, reg_data[3]}, 32'd1);
        check("R11 irq from overrun", {31'd0, irq}, 32'd1);
        do_read();
        overrun = 1'b0; tick();
        check("R4 overrun fall no set", {31'd0, reg_data[3]}, 32'd0);
        check("R11 irq low", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_wake();
        bus_active = 1'b1; tick();
        check("R5 activity awake no set", {31'd0, reg_data[4]}, 32'd0);
        sleeping = 1'b1; tick();
        check("R5 wake sets", {31'd0, reg_data[4]}, 32'd1);
        sleeping = 1'b0; bus_active = 1'b0;
        do_read();
        check("R6 read clears wake", {31'd0, reg_data[4]}, 32'd0);
        check("R6 pad bits zero", {23'd0, reg_data[15:7]}, 32'd0);
    endtask

    task automatic t_berr();
        berr_strobe = 1'b1; berr_code = 8'hA5; tick();
        berr_code = 8'h3C; tick();
        berr_strobe = 1'b0;
        check("R7 berr captured", {24'd0, reg_data[23:16]}, 32'hA5);
        check("R7 berr flag", {31'd0, reg_data[5]}, 32'd1);
        check("R9 held ignores strobe", {24'd0, reg_data[23:16]}, 32'hA5);
        do_read();
        check("R9 value kept after release", {24'd0, reg_data[23:16]}, 32'hA5);
        check("R6 berr flag cleared", {31'd0, reg_data[5]}, 32'd0);
        irq_en[5] = 1'b0; berr_strobe = 1'b1; berr_code = 8'h3C; tick();
        berr_strobe = 1'b0; irq_en[5] = 1'b1;
        check("R9 released byte recaptures", {24'd0, reg_data[23:16]}, 32'h3C);
        check("R7 disabled flag stays 0", {31'd0, reg_data[5]}, 32'd0);
        do_read();
    endtask

    task automatic t_arb();
        arb_strobe = 1'b1; arb_code = 8'h11; tick();
        arb_strobe = 1'b0;
        check("R8 arb captured", {24'd0, reg_data[31:24]}, 32'h11);
        check("R8 arb flag", {31'd0, reg_data[6]}, 32'd1);
        reg_rd = 1'b1; arb_strobe = 1'b1; arb_code = 8'h77; tick();
        reg_rd = 1'b0; arb_strobe = 1'b0;
        check("R10 set wins flag", {31'd0, reg_data[6]}, 32'd1);
        check("R10 set wins code", {24'd0, reg_data[31:24]}, 32'h77);
        arb_strobe = 1'b1; arb_code = 8'h22; tick();
        arb_strobe = 1'b0;
        check("R10 byte held again", {24'd0, reg_data[31:24]}, 32'h77);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        {rx_full, tx1_free, err_warn, bus_off, overrun, sleeping, bus_active} = '0;
        irq_en = 7'h7F;
        {berr_strobe, arb_strobe, reg_rd} = '0;
        berr_code = '0; arb_code = '0;
        tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_rx();
        t_tx1();
        t_err();
        t_ovr();
        t_wake();
        t_berr();
        t_arb();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule